// File: doc/BRIEF.md
# Tape Character Parity Channel

This block sits between a host port that moves 6-bit words and the head interface of a seven-track tape unit. In write mode each accepted host word goes out to the write head as a 7-bit character. The extra bit is an odd parity bit. The block also folds every data word into a running longitudinal check word. When the host marks the end of a block, that check word goes out as a closing character, and the check word then starts again from zero.

A second head sits behind the write head and reads back each character soon after it is recorded. Every character sent to the write head is held in a small first-in first-out queue. Each read-back character is compared with the oldest character still waiting. A value mismatch, a read-back character with even parity, or a read-back character with nothing waiting counts as an error. In read mode, characters from the tape pass to the host with the parity bit removed, and any character with even parity counts as an error.

Errors set a sticky flag that the host can sense and clear. By default the transfer goes on after an error. If the host raises a stop input, further write data is refused until the flag is cleared. Per-character parity does not depend on the direction of tape motion, so reverse reads need no special handling.

Top module: `tape_parity_channel`

## Requirements
- R1: A host word accepted in write mode (`wr_valid` and `wr_ready` both high at a clock edge) appears one cycle later on the write head port. `head_valid` is high, `head_char[5:0]` equals the word, and `head_char[6]` is the bit that makes the count of ones in all 7 bits odd.
- R2: An end-of-block request (`blk_end` high, `wr_valid` low, `wr_ready` high) emits, one cycle later, a character whose low 6 bits are the XOR of all words accepted since the previous end-of-block or reset, with odd parity in bit 6. The accumulated XOR then restarts at zero.
- R3: In read mode, a character presented with `rd_valid` appears one cycle later on the host side: `host_valid` is high and `host_data` equals bits 5:0 of that character.
- R4: A read-mode character with an even count of ones sets `err_flag` one cycle later, and that character is still forwarded to the host.
- R5: In write mode, each `readback_valid` character is compared with the oldest written character not yet matched, in write order. `err_flag` is set one cycle later if the two differ, if the read-back character has even parity, or if no written character is waiting.
- R6: `err_flag` stays high until `err_clear` is asserted, and it is low in the cycle after the clear. If a new error arrives in the same cycle as `err_clear`, the flag stays high.
- R7: While `stop_on_error` and `err_flag` are both high, `wr_ready` is low and write data does not reach the head. With `stop_on_error` low, writes are still accepted while the flag is set.
- R8: `wr_ready` is low while DEPTH written characters are waiting for read-back. One read-back frees a slot for the next cycle.
- R9: In read mode, `wr_ready` is low and read-back characters raise no error. In write mode, `rd_valid` produces no host output.
- R10: After reset, `head_valid`, `host_valid` and `err_flag` are low, `wr_ready` is high in write mode, and the longitudinal check word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_rd | input | 1 | 1 = read mode, 0 = write mode |
| stop_on_error | input | 1 | Refuse write data while the error flag is set |
| wr_valid | input | 1 | Host offers a data word |
| wr_data | input | DW | Host data word |
| blk_end | input | 1 | Request the closing longitudinal character |
| wr_ready | output | 1 | Block can take a word or end-of-block request |
| head_valid | output | 1 | Character presented to the write head |
| head_char | output | DW+1 | Character to the write head, parity in the top bit |
| readback_valid | input | 1 | Trailing head delivers a character |
| readback_char | input | DW+1 | Character read back behind the write head |
| rd_valid | input | 1 | Tape character present in read mode |
| rd_char | input | DW+1 | Tape character read |
| host_valid | output | 1 | Read data valid to the host |
| host_data | output | DW | Read data without parity |
| err_flag | output | 1 | Sticky parity or compare error |
| err_clear | input | 1 | Clear the error flag |

## Verification
If the queue pointers or the occupancy count go wrong, the read-back compare goes wrong. The error flag then rises one cycle after the first read-back that meets the wrong entry, or `wr_ready` drops too early or too late. A longitudinal word that was not cleared, or that took in a word twice, shows only at the next closing character, so every block ends with a check of that character. A wrong parity sense shows on the very first head character or tape character.

// File: rtl/tape_parity_channel.sv
module tape_parity_channel #(
  parameter int DEPTH = 4,
  parameter int DW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_rd,
  input  logic          stop_on_error,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          blk_end,
  output logic          wr_ready,
  output logic          head_valid,
  output logic [DW:0]   head_char,
  input  logic          readback_valid,
  input  logic [DW:0]   readback_char,
  input  logic          rd_valid,
  input  logic [DW:0]   rd_char,
  output logic          host_valid,
  output logic [DW-1:0] host_data,
  output logic          err_flag,
  input  logic          err_clear
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [DW:0]     mem [DEPTH];
  logic [AW-1:0]   wptr, rptr;
  logic [CNTW-1:0] cnt;
  logic [DW-1:0]   lrc;

  logic          wr_fire, blk_fire, push, pop, rb_live, rb_has, rb_err, rd_live, rd_err;
  logic [DW-1:0] out_word;
  logic [DW:0]   out_char;

  assign wr_ready = !mode_rd && !(stop_on_error && err_flag) && (cnt != CNTW'(DEPTH));
  assign wr_fire  = wr_valid && wr_ready;
  assign blk_fire = blk_end && !wr_valid && wr_ready;
  assign push     = wr_fire || blk_fire;
  assign out_word = blk_fire ? lrc : wr_data;
  assign out_char = {~^out_word, out_word};

  assign rb_live = readback_valid && !mode_rd;
  assign rb_has  = (cnt != '0);
  assign pop     = rb_live && rb_has;
  assign rb_err  = rb_live && (!rb_has || (readback_char != mem[rptr]) || !(^readback_char));
  assign rd_live = rd_valid && mode_rd;
  assign rd_err  = rd_live && !(^rd_char);

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= out_char;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr       <= '0;
      rptr       <= '0;
      cnt        <= '0;
      lrc        <= '0;
      head_valid <= 1'b0;
      head_char  <= '0;
      host_valid <= 1'b0;
      host_data  <= '0;
      err_flag   <= 1'b0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      cnt <= cnt + CNTW'(push) - CNTW'(pop);
      if (blk_fire)     lrc <= '0;
      else if (wr_fire) lrc <= lrc ^ wr_data;
      head_valid <= push;
      if (push) head_char <= out_char;
      host_valid <= rd_live;
      if (rd_live) host_data <= rd_char[DW-1:0];
      if (rb_err || rd_err) err_flag <= 1'b1;
      else if (err_clear)   err_flag <= 1'b0;
    end
  end
endmodule

module tape_parity_channel_chk #(
  parameter int DEPTH = 4,
  parameter int DW    = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       mode_rd,
  input logic                       stop_on_error,
  input logic                       wr_valid,
  input logic [DW-1:0]              wr_data,
  input logic                       wr_ready,
  input logic                       head_valid,
  input logic [DW:0]                head_char,
  input logic                       rd_valid,
  input logic [DW:0]                rd_char,
  input logic                       host_valid,
  input logic [DW-1:0]              host_data,
  input logic                       err_flag,
  input logic                       err_clear,
  input logic [$clog2(DEPTH+1)-1:0] cnt
);
  assert_char_odd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    head_valid |-> (^head_char));
  assert_write_echo_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (head_valid && head_char[DW-1:0] == $past(wr_data)));
  assert_read_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rd && rd_valid) |=> (host_valid && host_data == $past(rd_char[DW-1:0])));
  assert_read_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rd && rd_valid && !(^rd_char)) |=> err_flag);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clear) |=> err_flag);
  assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_on_error && err_flag) |-> !wr_ready);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(DEPTH+1))'(DEPTH));
  assert_mode_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rd |-> !wr_ready);
  assert_mode_host_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_rd |=> !host_valid);
endmodule

bind tape_parity_channel tape_parity_channel_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_rd(mode_rd), .stop_on_error(stop_on_error),
  .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
  .head_valid(head_valid), .head_char(head_char), .rd_valid(rd_valid),
  .rd_char(rd_char), .host_valid(host_valid), .host_data(host_data),
  .err_flag(err_flag), .err_clear(err_clear), .cnt(cnt)
);

// File: tb/tape_parity_channel_bench.sv
module tape_parity_channel_bench;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_rd = 1'b0, stop_on_error = 1'b0, wr_valid = 1'b0, blk_end = 1'b0;
  logic [5:0] wr_data = '0;
  logic readback_valid = 1'b0, rd_valid = 1'b0, err_clear = 1'b0;
  logic [6:0] readback_char = '0, rd_char = '0;
  logic wr_ready, head_valid, host_valid, err_flag;
  logic [6:0] head_char;
  logic [5:0] host_data;

  int tests = 0;
  int fails = 0;
  logic [5:0] exp_lrc = '0;
  logic [6:0] q[$];

  always #5 clk = ~clk;

  tape_parity_channel #(.DEPTH(DEPTH), .DW(6)) u_tape_parity_channel (
    .clk(clk), .rst_n(rst_n), .mode_rd(mode_rd), .stop_on_error(stop_on_error),
    .wr_valid(wr_valid), .wr_data(wr_data), .blk_end(blk_end), .wr_ready(wr_ready),
    .head_valid(head_valid), .head_char(head_char),
    .readback_valid(readback_valid), .readback_char(readback_char),
    .rd_valid(rd_valid), .rd_char(rd_char), .host_valid(host_valid),
    .host_data(host_data), .err_flag(err_flag), .err_clear(err_clear)
  );

  function automatic logic [6:0] enc(input logic [5:0] d);
    int ones = 0;
    for (int i = 0; i < 6; i++) ones += d[i];
    return {(ones % 2 == 0) ? 1'b1 : 1'b0, d};
  endfunction

  function automatic logic even7(input logic [6:0] c);
    int ones = 0;
    for (int i = 0; i < 7; i++) ones += c[i];
    return (ones % 2) == 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_word(input logic [5:0] d);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    check("R1 head_valid", int'(head_valid), 1);
    check("R1 head_char", int'(head_char), int'(enc(d)));
    exp_lrc ^= d;
    q.push_back(enc(d));
  endtask

  task automatic end_block();
    blk_end = 1'b1;
    @(negedge clk);
    blk_end = 1'b0;
    check("R2 lrc valid", int'(head_valid), 1);
    check("R2 lrc char", int'(head_char), int'(enc(exp_lrc)));
    q.push_back(enc(exp_lrc));
    exp_lrc = '0;
  endtask

  task automatic readback(input logic [6:0] c);
    readback_valid = 1'b1; readback_char = c;
    @(negedge clk);
    readback_valid = 1'b0;
  endtask

  task automatic rb_good();
    readback(q.pop_front());
    check("R5 match no error", int'(err_flag), 0);
  endtask

  task automatic clear_err();
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    check("R6 cleared", int'(err_flag), 0);
  endtask

  task automatic read_char(input logic [6:0] c);
    rd_valid = 1'b1; rd_char = c;
    @(negedge clk);
    rd_valid = 1'b0;
    check("R3 host_valid", int'(host_valid), 1);
    check("R3 host_data", int'(host_data), int'(c[5:0]));
    check("R4 parity error", int'(err_flag), int'(even7(c)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [6:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 head_valid", int'(head_valid), 0);
    check("R10 host_valid", int'(host_valid), 0);
    check("R10 err_flag", int'(err_flag), 0);
    check("R10 wr_ready", int'(wr_ready), 1);
    end_block();
    rb_good();

    for (int d = 0; d < 64; d++) begin
      check("R8 ready", int'(wr_ready), 1);
      write_word(6'(d));
      rb_good();
    end
    end_block();
    rb_good();

    write_word(6'h05); write_word(6'h09); write_word(6'h3C);
    end_block();
    repeat (4) rb_good();

    write_word(6'h15);
    c = q.pop_front();
    readback(c ^ 7'h03);
    check("R5 value mismatch", int'(err_flag), 1);
    check("R7 ready without stop", int'(wr_ready), 1);
    write_word(6'h07);
    readback(q.pop_front());
    check("R6 sticky", int'(err_flag), 1);
    stop_on_error = 1'b1;
    #1 check("R7 ready with stop", int'(wr_ready), 0);
    wr_valid = 1'b1; wr_data = 6'h11;
    @(negedge clk);
    wr_valid = 1'b0;
    check("R7 no head write", int'(head_valid), 0);
    clear_err();
    check("R7 ready after clear", int'(wr_ready), 1);
    stop_on_error = 1'b0;

    write_word(6'h2A);
    c = q.pop_front();
    readback(c ^ 7'h40);
    check("R5 readback parity", int'(err_flag), 1);
    clear_err();
    readback(7'h40);
    check("R5 readback empty", int'(err_flag), 1);
    clear_err();

    for (int i = 0; i < DEPTH; i++) write_word(6'(8 * i + 3));
    check("R8 full", int'(wr_ready), 0);
    rb_good();
    check("R8 slot freed", int'(wr_ready), 1);
    repeat (DEPTH - 1) rb_good();
    end_block();
    rb_good();

    mode_rd = 1'b1;
    #1 check("R9 ready read mode", int'(wr_ready), 0);
    readback(7'h00);
    check("R9 readback ignored", int'(err_flag), 0);
    for (int v = 0; v < 128; v++) begin
      read_char(7'(v));
      if (err_flag) clear_err();
    end
    read_char(7'h00);
    rd_valid = 1'b1; rd_char = 7'h03; err_clear = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0; err_clear = 1'b0;
    check("R6 set wins over clear", int'(err_flag), 1);
    clear_err();
    mode_rd = 1'b0;
    rd_valid = 1'b1; rd_char = 7'h01;
    @(negedge clk);
    rd_valid = 1'b0;
    check("R9 rd ignored in write", int'(host_valid), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule